// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Front End

This block lets a memory core sit on a microcontroller bus in which the low address byte and the data share eight lines. A strobe signals the address phase, an enable signals the data phase, and a direction signal selects read or write. All control inputs are sampled with the system clock and turned into single-cycle read and write strobes for the core. A 13-bit address is assembled from the shared lines and five dedicated upper address pins. While the address strobe is high, the address follows the pins. It is frozen once the synchronized strobe falls.

For reads, the block drives the shared lines with the core's data only while the data phase is active, the chip is selected and the direction is read. For writes, it captures the byte on the shared lines when the enable falls and issues one write strobe. A write-lock input suppresses that strobe without affecting reads. The top address bit selects one of two 4K planes. When the chip is deselected and the address strobe is low, the block reports standby.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, `addr_o` is 0, `plane_o` is 0, both strobes are low and `ad_oe` is low.
- R2: While the synchronized address strobe is high, `addr_o` follows `{ahi_i, ad_i}`, with `ad_i` as bits 7:0 and `ahi_i` as bits 12:8.
- R3: After the address strobe falls, later changes on `ad_i` and `ahi_i` leave `addr_o` unchanged until the strobe rises again.
- R4: In a read, with CE high and R/W high, exactly one `rd_stb_o` pulse of one cycle occurs per E high phase. From the cycle after that pulse, `ad_o` holds the value of `rd_data_i` sampled at the pulse.
- R5: `ad_oe` is high only while the synchronized E, CE and R/W are all high. It is low whenever any of them is low, including for the whole of a write.
- R6: In a write, with CE high, R/W low and write lock low, exactly one `wr_stb_o` pulse of one cycle occurs after E falls. During that pulse, `wr_data_o` equals the byte on `ad_i`.
- R7: While `wlock_i` is high, no `wr_stb_o` pulse is produced, and reads still produce their strobe and data.
- R8: While CE is low, neither strobe pulses and `ad_oe` stays low.
- R9: `standby_o` is high exactly when the synchronized CE and AS are both low.
- R10: `plane_o` equals bit 12 of the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_i | input | 1 | Address strobe, high during the address phase |
| e_i | input | 1 | Data-phase enable |
| rw_i | input | 1 | Direction, 1 for read and 0 for write |
| ce_i | input | 1 | Chip enable, active high |
| wlock_i | input | 1 | Write lock, high to suppress writes |
| ad_i | input | 8 | Shared address/data lines, input side |
| ahi_i | input | 5 | Upper address pins |
| ad_o | output | 8 | Shared lines, output data |
| ad_oe | output | 1 | Output enable for the shared lines; low means high impedance |
| addr_o | output | 13 | Latched address to the core |
| plane_o | output | 1 | Plane select, latched address bit 12 |
| rd_stb_o | output | 1 | One-cycle read strobe to the core |
| rd_data_i | input | 8 | Read data from the core |
| wr_stb_o | output | 1 | One-cycle write strobe to the core |
| wr_data_o | output | 8 | Captured write byte |
| standby_o | output | 1 | Standby indication |

## Verification
The assertions assume the bus master holds the shared address lines for at least three clocks after AS falls. They also assume it holds write data for at least three clocks after E falls. These holds cover the two-stage synchronizer delay between a control edge and its detection. The assertions further assume that E, R/W and CE change only as whole phases that last several clocks. The bench master keeps four-clock holds around every strobe edge. It changes R/W and CE only while E is low, so every edge it produces is seen once, in order.

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int LO_W        = 8,
  parameter int HI_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 as_i,
  input  logic                 e_i,
  input  logic                 rw_i,
  input  logic                 ce_i,
  input  logic                 wlock_i,
  input  logic [LO_W-1:0]      ad_i,
  input  logic [HI_W-1:0]      ahi_i,
  output logic [LO_W-1:0]      ad_o,
  output logic                 ad_oe,
  output logic [LO_W+HI_W-1:0] addr_o,
  output logic                 plane_o,
  output logic                 rd_stb_o,
  input  logic [LO_W-1:0]      rd_data_i,
  output logic                 wr_stb_o,
  output logic [LO_W-1:0]      wr_data_o,
  output logic                 standby_o
);
  localparam int ADDR_W = LO_W + HI_W;
  localparam int NCTL   = 5;

  logic [SYNC_STAGES-1:0][NCTL-1:0] sync_q;
  logic as_s, e_s, rw_s, ce_s, wc_s, e_d;
  logic e_rise, e_fall;
  logic [ADDR_W-1:0] addr_q;
  logic [LO_W-1:0]   rd_q, wr_q;
  logic              rd_stb_q, wr_stb_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], {as_i, e_i, rw_i, ce_i, wlock_i}};

  assign {as_s, e_s, rw_s, ce_s, wc_s} = sync_q[SYNC_STAGES-1];

  assign e_rise = e_s & ~e_d;
  assign e_fall = ~e_s & e_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e_d      <= 1'b0;
      addr_q   <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      rd_stb_q <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      e_d      <= e_s;
      if (as_s) addr_q <= {ahi_i, ad_i};
      rd_stb_q <= e_rise & ce_s & rw_s;
      wr_stb_q <= e_fall & ce_s & ~rw_s & ~wc_s;
      if (rd_stb_q) rd_q <= rd_data_i;
      if (e_fall & ce_s & ~rw_s) wr_q <= ad_i;
    end

  assign addr_o    = addr_q;
  assign plane_o   = addr_q[ADDR_W-1];
  assign rd_stb_o  = rd_stb_q;
  assign wr_stb_o  = wr_stb_q;
  assign wr_data_o = wr_q;
  assign ad_o      = rd_q;
  assign ad_oe     = e_s & ce_s & rw_s;
  assign standby_o = ~ce_s & ~as_s;
endmodule

// File: rtl/mux_bus_slave_chk.sv
module mux_bus_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_s,
  input logic              ce_s,
  input logic              wc_s,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_stb_o,
  input logic              wr_stb_o,
  input logic              ad_oe,
  input logic              standby_o
);
  p_addr_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(as_s) |-> $stable(addr_o));
  p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |=> !rd_stb_o);
  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb_o && wr_stb_o));
  p_wr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !$past(wc_s));
  p_rd_needs_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> $past(ce_s));
  p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !ad_oe);
endmodule

bind mux_bus_slave mux_bus_slave_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .as_s(as_s), .ce_s(ce_s), .wc_s(wc_s),
  .addr_o(addr_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
  .ad_oe(ad_oe), .standby_o(standby_o)
);

// File: tb/test_mux_bus_slave.sv
module test_mux_bus_slave;
  logic clk = 0, rst_n = 0;
  logic as_i = 0, e_i = 0, rw_i = 1, ce_i = 0, wlock_i = 0;
  logic [7:0] ad_i = 0;
  logic [4:0] ahi_i = 0;
  logic [7:0] ad_o, wr_data_o, rd_data_i;
  logic [12:0] addr_o;
  logic ad_oe, plane_o, rd_stb_o, wr_stb_o, standby_o;
  int checks = 0, failures = 0;
  int rd_cnt, wr_cnt, oe_cnt;
  logic [7:0] last_wr;

  always #4 clk = ~clk;

  assign rd_data_i = addr_o[7:0] ^ {3'b000, addr_o[12:8]};

  mux_bus_slave i_mux_bus_slave (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .e_i(e_i), .rw_i(rw_i), .ce_i(ce_i),
    .wlock_i(wlock_i), .ad_i(ad_i), .ahi_i(ahi_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .addr_o(addr_o), .plane_o(plane_o), .rd_stb_o(rd_stb_o), .rd_data_i(rd_data_i),
    .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o), .standby_o(standby_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      if (rd_stb_o) rd_cnt++;
      if (wr_stb_o) begin wr_cnt++; last_wr = wr_data_o; end
      if (ad_oe) oe_cnt++;
    end
  endtask

  task automatic clr();
    rd_cnt = 0; wr_cnt = 0; oe_cnt = 0; last_wr = 0;
  endtask

  task automatic put_addr(logic [12:0] a);
    @(negedge clk); as_i = 1; ad_i = a[7:0]; ahi_i = a[12:8];
    run(4);
    as_i = 0;
    run(4);
  endtask

  task automatic t_reset();
    check("R1 addr", addr_o, 0);
    check("R1 plane", plane_o, 0);
    check("R1 strobes", {rd_stb_o, wr_stb_o}, 0);
    check("R1 oe", ad_oe, 0);
  endtask

  task automatic t_transparent();
    @(negedge clk); as_i = 1; ad_i = 8'h3c; ahi_i = 5'h05;
    run(4);
    check("R2 follow1", addr_o, 13'h053c);
    ad_i = 8'hc3; ahi_i = 5'h1a;
    run(4);
    check("R2 follow2", addr_o, 13'h1ac3);
    as_i = 0; run(4);
  endtask

  task automatic t_freeze(logic [12:0] a);
    put_addr(a);
    ad_i = ~a[7:0]; ahi_i = ~a[12:8];
    run(6);
    check("R3 frozen", addr_o, a);
    check("R10 plane", plane_o, a[12]);
  endtask

  task automatic t_read(logic [12:0] a, logic wl);
    logic [7:0] exp = a[7:0] ^ {3'b000, a[12:8]};
    ce_i = 1; rw_i = 1; wlock_i = wl;
    put_addr(a);
    clr();
    e_i = 1; run(8);
    check(wl ? "R7 read under lock" : "R4 read data", ad_o, exp);
    check("R5 oe in read", ad_oe, 1);
    e_i = 0; run(4);
    check("R4 one rd pulse", rd_cnt, 1);
    check("R5 oe off after E", ad_oe, 0);
    wlock_i = 0;
  endtask

  task automatic t_write(logic [12:0] a, logic [7:0] d, logic wl);
    ce_i = 1; rw_i = 0; wlock_i = wl;
    put_addr(a);
    clr();
    e_i = 1; ad_i = d; run(6);
    e_i = 0; run(6);
    if (wl) check("R7 write blocked", wr_cnt, 0);
    else begin
      check("R6 one wr pulse", wr_cnt, 1);
      check("R6 wr data", last_wr, d);
    end
    check("R5 oe off in write", oe_cnt, 0);
    rw_i = 1; wlock_i = 0; run(2);
  endtask

  task automatic t_deselected();
    ce_i = 0; rw_i = 1;
    put_addr(13'h0777);
    clr();
    e_i = 1; run(6); e_i = 0; run(4);
    rw_i = 0; e_i = 1; ad_i = 8'h99; run(6); e_i = 0; run(6); rw_i = 1;
    check("R8 no strobes", rd_cnt + wr_cnt, 0);
    check("R8 no oe", oe_cnt, 0);
  endtask

  task automatic t_standby();
    ce_i = 0; as_i = 0; run(4);
    check("R9 standby on", standby_o, 1);
    as_i = 1; run(4);
    check("R9 standby off as", standby_o, 0);
    as_i = 0; ce_i = 1; run(4);
    check("R9 standby off ce", standby_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    run(2);
    t_transparent();
    t_freeze(13'h1a5f);
    t_freeze(13'h0123);
    t_read(13'h1234, 0);
    t_read(13'h0fe0, 0);
    t_write(13'h0455, 8'ha7, 0);
    t_write(13'h1aaa, 8'h5e, 0);
    t_write(13'h0455, 8'h11, 1);
    t_read(13'h1001, 1);
    t_deselected();
    t_standby();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule